// File: doc/BRIEF.md
# Sixteen-Line GPIO Controller with Edge Interrupts

This block is a small general-purpose I/O port with a 16-bit register interface. Each of its lines can be an input or a driven output. Software sets the direction, the output data and, for each line, whether a rising or a falling transition counts as an event. Input lines pass through a two-flop synchroniser before they are sampled. Edges are found by comparing the new synchronised sample with the one before it.

Events on unmasked input lines set bits in a sticky status register. Any set status bit raises a single interrupt request. Software clears status bits by writing ones to them. A pin-control register selects which synchronised inputs are visible when the data-in register is read.

Register writes use a one-cycle strobe made of valid, write, address, size and data. A read strobe returns its data, together with a one-cycle valid pulse, on the cycle after the strobe. Only 16-bit accesses are accepted.

Top module: `gpio_edge_ctl`

## Requirements
- R1: After reset, reads return the following values:
  - data-out, direction, edge polarity, mask and pin control read 0xFFFF.
  - Status and data-in read 0.
  - pin_oe is 0 and irq is low.
- R2: A read strobe (bus_valid=1, bus_write=0) gives rd_valid=1 with rd_data on the next cycle only. With no read strobe, rd_valid is 0 on the following cycle.
- R3: Reading data-in returns the input sample ANDed with pin control. The sample is taken through two flops, so a read strobe issued in the same cycle that an input changes still returns the old value.
- R4: A direction bit of 1 makes that line an input. pin_oe is the inverse of the direction register. pin_out carries the data-out bit where pin_oe is 1 and is 0 elsewhere. A direction write that turns a line into an output drives that line's current data-out bit on the next cycle.
- R5: An edge-polarity bit of 1 selects rising-edge detection for that line. A bit of 0 selects falling-edge detection.
- R6: A detected edge sets its status bit only when the line is an input (direction 1) and its mask bit is 0.
- R7: Writing status clears each bit written as 1 and leaves the other bits unchanged.
- R8: irq is high exactly while at least one status bit is set. It drops only after a status write.
- R9: Only accesses with bus_size code 2'b01 (16-bit) are accepted. For any other size code, writes change nothing and reads return 0 with rd_valid still pulsed.
- R10: Writes to data-in change nothing. Reads of an unmapped offset return 0, and writes to one change nothing.
- R11: The register offsets are:
  - 0x00 data-in
  - 0x04 data-out
  - 0x08 direction
  - 0x0C edge polarity
  - 0x10 mask
  - 0x14 status
  - 0x18 pin control

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access size code (2'b00 byte, 2'b01 half-word, 2'b10 word) |
| bus_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read strobe |
| rd_data | output | 16 | Read data |
| pin_in | input | 16 | Asynchronous external input levels |
| pin_out | output | 16 | Output levels for driven lines |
| pin_oe | output | 16 | Per-line output enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that at most one access is presented per cycle, since each strobe is a single cycle. They also assume that pin_out and pin_oe can move only because of an accepted register write. This holds because the stimulus drives every access strobe and every pin change at the falling clock edge, and always returns bus_valid to 0 after one cycle. The check that irq falls only after a status write relies on the bench never issuing a reset in the middle of a run. The bench holds each input pattern for several cycles before reading the result, so each edge crosses the synchroniser as one clean transition.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;

   typedef enum logic [ADDR_W-1:0] {
      OFF_DIN  = 8'h00,
      OFF_DOUT = 8'h04,
      OFF_DIR  = 8'h08,
      OFF_POL  = 8'h0C,
      OFF_MASK = 8'h10,
      OFF_STAT = 8'h14,
      OFF_PINC = 8'h18
   } reg_off_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_RSVD = 2'b11
   } acc_size_e;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d_async;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sample,
   input  logic [W-1:0] rise_sel,
   input  logic [W-1:0] is_input,
   input  logic [W-1:0] masked,
   output logic [W-1:0] event_hit
);
   logic [W-1:0] prev_q;
   logic [W-1:0] rise_w;
   logic [W-1:0] fall_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sample;
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_line
         assign rise_w[i]    = sample[i] & ~prev_q[i];
         assign fall_w[i]    = ~sample[i] & prev_q[i];
         assign event_hit[i] = (rise_sel[i] ? rise_w[i] : fall_w[i])
                               & is_input[i] & ~masked[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
   import gpio_edge_pkg::*;
#(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic [W-1:0]      sample,
   input  logic [W-1:0]      event_hit,
   output logic [W-1:0]      dout_q,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      pol_q,
   output logic [W-1:0]      mask_q,
   output logic [W-1:0]      stat_q
);
   logic [W-1:0]      pinc_q;
   logic              size_ok;
   logic              wr_ok;
   logic              rd_ok;
   logic [W-1:0]      wval;
   logic [W-1:0]      clr_bits;
   logic [W-1:0]      sel_val;
   logic              sel_hit;
   logic [DATA_W-1:0] rd_ext;

   assign size_ok  = (bus_size == SZ_HALF);
   assign wr_ok    = bus_valid & bus_write & size_ok;
   assign rd_ok    = bus_valid & ~bus_write & size_ok;
   assign wval     = bus_wdata[W-1:0];
   assign clr_bits = (wr_ok && bus_addr == OFF_STAT) ? wval : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '1;
         dir_q  <= '1;
         pol_q  <= '1;
         mask_q <= '1;
         pinc_q <= '1;
         stat_q <= '0;
      end else begin
         if (wr_ok) begin
            case (bus_addr)
               OFF_DOUT: dout_q <= wval;
               OFF_DIR:  dir_q  <= wval;
               OFF_POL:  pol_q  <= wval;
               OFF_MASK: mask_q <= wval;
               OFF_PINC: pinc_q <= wval;
               default:  ;
            endcase
         end
         stat_q <= (stat_q & ~clr_bits) | event_hit;
      end
   end

   always_comb begin
      sel_hit = 1'b1;
      case (bus_addr)
         OFF_DIN:  sel_val = sample & pinc_q;
         OFF_DOUT: sel_val = dout_q;
         OFF_DIR:  sel_val = dir_q;
         OFF_POL:  sel_val = pol_q;
         OFF_MASK: sel_val = mask_q;
         OFF_STAT: sel_val = stat_q;
         OFF_PINC: sel_val = pinc_q;
         default: begin
            sel_val = '0;
            sel_hit = 1'b0;
         end
      endcase
      rd_ext = '0;
      if (sel_hit) rd_ext[W-1:0] = sel_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= bus_valid & ~bus_write;
         rd_data  <= rd_ok ? rd_ext : '0;
      end
   end
endmodule

// File: rtl/gpio_edge_ctl.sv
module gpio_edge_ctl
   import gpio_edge_pkg::*;
#(
   parameter int NLINES      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic [NLINES-1:0] pin_in,
   output logic [NLINES-1:0] pin_out,
   output logic [NLINES-1:0] pin_oe,
   output logic              irq
);
   generate
      if (NLINES < 1 || NLINES > DATA_W) begin : g_bad_lines
         $error("gpio_edge_ctl: NLINES must be in 1..DATA_W");
      end
   endgenerate

   logic [NLINES-1:0] sample;
   logic [NLINES-1:0] event_hit;
   logic [NLINES-1:0] dout_q;
   logic [NLINES-1:0] dir_q;
   logic [NLINES-1:0] pol_q;
   logic [NLINES-1:0] mask_q;
   logic [NLINES-1:0] stat_q;

   gpio_sync_chain #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (sample)
   );

   gpio_edge_det #(.W(NLINES)) u_det (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample    (sample),
      .rise_sel  (pol_q),
      .is_input  (dir_q),
      .masked    (mask_q),
      .event_hit (event_hit)
   );

   gpio_edge_regs #(.W(NLINES)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wdata (bus_wdata),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .sample    (sample),
      .event_hit (event_hit),
      .dout_q    (dout_q),
      .dir_q     (dir_q),
      .pol_q     (pol_q),
      .mask_q    (mask_q),
      .stat_q    (stat_q)
   );

   // Output drive follows the direction register directly, so a direction
   // flip re-drives the held data-out bit on the following cycle.
   assign pin_oe  = ~dir_q;
   assign pin_out = dout_q & ~dir_q;
   assign irq     = |stat_q;
endmodule

// File: rtl/gpio_edge_ctl_chk.sv
module gpio_edge_ctl_chk
   import gpio_edge_pkg::*;
#(
   parameter int NLINES = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_valid,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic [NLINES-1:0] pin_out,
   input logic [NLINES-1:0] pin_oe,
   input logic              irq
);
   // R2
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write) |=> rd_valid);

   // R2
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && !bus_write) |=> !rd_valid);

   // R9
   bad_size_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_write && bus_size != SZ_HALF) |=> (rd_data == '0));

   // R9
   bad_size_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_size != SZ_HALF)
      |=> ($stable(pin_out) && $stable(pin_oe)));

   // R4
   undriven_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0));

   // R8
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(bus_valid && bus_write && bus_size == SZ_HALF
                           && bus_addr == OFF_STAT));
endmodule

bind gpio_edge_ctl gpio_edge_ctl_chk #(.NLINES(NLINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_valid (bus_valid),
   .bus_write (bus_write),
   .bus_addr  (bus_addr),
   .bus_size  (bus_size),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .irq       (irq)
);

// File: tb/gpio_edge_ctl_tb.sv
module gpio_edge_ctl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [1:0]  bus_size = 2'b01;
   logic [15:0] bus_wdata = '0;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic [15:0] pin_in = '0;
   logic [15:0] pin_out;
   logic [15:0] pin_oe;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [15:0] rv;

   localparam logic [7:0] A_DIN  = 8'h00;
   localparam logic [7:0] A_DOUT = 8'h04;
   localparam logic [7:0] A_DIR  = 8'h08;
   localparam logic [7:0] A_POL  = 8'h0C;
   localparam logic [7:0] A_MASK = 8'h10;
   localparam logic [7:0] A_STAT = 8'h14;
   localparam logic [7:0] A_PINC = 8'h18;

   // {polarity, mask, direction, start pins, end pins, expected status}
   localparam int NV = 6;
   localparam logic [95:0] VEC [NV] = '{
      {16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'h00FF, 16'h00FF},
      {16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hF0F0, 16'h0F0F},
      {16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000},
      {16'hFFFF, 16'hFF00, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h00FF},
      {16'hFFFF, 16'h0000, 16'h00FF, 16'h0000, 16'hFFFF, 16'h00FF},
      {16'h00FF, 16'h0000, 16'hFFFF, 16'h0F0F, 16'hF0F0, 16'h0FF0}
   };

   gpio_edge_ctl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_valid (bus_valid),
      .bus_write (bus_write),
      .bus_addr  (bus_addr),
      .bus_size  (bus_size),
      .bus_wdata (bus_wdata),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   always #2 clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d,
                     input logic [1:0] sz = 2'b01);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a;
      bus_size = sz; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; bus_size = 2'b01;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d,
                     input logic [1:0] sz = 2'b01);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = sz;
      @(negedge clk);
      bus_valid = 1'b0; bus_size = 2'b01;
      chk("R2", "rd_valid after strobe", {15'd0, rd_valid}, 16'h0001);
      d = rd_data;
      @(negedge clk);
      chk("R2", "rd_valid idle", {15'd0, rd_valid}, 16'h0000);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1 / R11 reset state through the register map
      rd(A_DOUT, rv); chk("R1", "data-out reset", rv, 16'hFFFF);
      rd(A_DIR,  rv); chk("R1", "direction reset", rv, 16'hFFFF);
      rd(A_POL,  rv); chk("R1", "polarity reset", rv, 16'hFFFF);
      rd(A_MASK, rv); chk("R1", "mask reset", rv, 16'hFFFF);
      rd(A_PINC, rv); chk("R11", "pin control reset", rv, 16'hFFFF);
      rd(A_STAT, rv); chk("R1", "status reset", rv, 16'h0000);
      rd(A_DIN,  rv); chk("R1", "data-in reset", rv, 16'h0000);
      chk("R1", "pin_oe reset", pin_oe, 16'h0000);
      chk("R1", "irq reset", {15'd0, irq}, 16'h0000);

      // R5 R6 R8 vector walk
      for (int i = 0; i < NV; i++) begin
         logic [95:0] v;
         v = VEC[i];
         wr(A_DIR,  v[63:48]);
         wr(A_POL,  v[95:80]);
         wr(A_MASK, v[79:64]);
         pin_in = v[47:32];
         idle(5);
         wr(A_STAT, 16'hFFFF);
         pin_in = v[31:16];
         idle(5);
         rd(A_STAT, rv);
         chk("R5/R6", $sformatf("vector %0d status", i), rv, v[15:0]);
         chk("R8", $sformatf("vector %0d irq", i), {15'd0, irq},
             {15'd0, (v[15:0] != 16'h0)});
      end
      wr(A_STAT, 16'hFFFF);
      idle(1);
      chk("R8", "irq after full clear", {15'd0, irq}, 16'h0000);

      // R7 partial clear leaves other bits, R8 irq tracks them
      wr(A_DIR, 16'hFFFF); wr(A_POL, 16'hFFFF); wr(A_MASK, 16'h0000);
      pin_in = 16'h0000; idle(5); wr(A_STAT, 16'hFFFF);
      pin_in = 16'h00FF; idle(5);
      wr(A_STAT, 16'h000F);
      rd(A_STAT, rv); chk("R7", "partial clear", rv, 16'h00F0);
      chk("R8", "irq held", {15'd0, irq}, 16'h0001);
      wr(A_STAT, 16'h00F0);
      idle(1);
      chk("R8", "irq dropped", {15'd0, irq}, 16'h0000);
      wr(A_MASK, 16'hFFFF);

      // R3 two-flop delay and pin-control gating
      pin_in = 16'h1234;
      rd(A_DIN, rv); chk("R3", "data-in before sync", rv, 16'h00FF);
      idle(3);
      rd(A_DIN, rv); chk("R3", "data-in after sync", rv, 16'h1234);
      wr(A_PINC, 16'h00FF);
      rd(A_DIN, rv); chk("R3", "data-in gated", rv, 16'h0034);

      // R10 data-in write and unmapped offset
      wr(A_DIN, 16'hFFFF);
      rd(A_DIN, rv); chk("R10", "data-in write ignored", rv, 16'h0034);
      wr(8'h1C, 16'hBEEF);
      rd(8'h1C, rv); chk("R10", "unmapped read", rv, 16'h0000);

      // R4 output drive follows direction
      wr(A_DOUT, 16'hA5A5);
      chk("R4", "pin_oe all inputs", pin_oe, 16'h0000);
      chk("R4", "pin_out all inputs", pin_out, 16'h0000);
      wr(A_DIR, 16'hFF00);
      chk("R4", "pin_oe after dir", pin_oe, 16'h00FF);
      chk("R4", "pin_out after dir", pin_out, 16'h00A5);
      wr(A_DIR, 16'h0F00);
      chk("R4", "pin_out more outputs", pin_out, 16'hA0A5);

      // R9 size rejection
      wr(A_DOUT, 16'h1111, 2'b10);
      chk("R9", "pin_out after word write", pin_out, 16'hA0A5);
      rd(A_DOUT, rv); chk("R9", "data-out after bad writes", rv, 16'hA5A5);
      wr(A_DOUT, 16'h2222, 2'b00);
      rd(A_DOUT, rv); chk("R9", "data-out after byte write", rv, 16'hA5A5);
      rd(A_DOUT, rv, 2'b00); chk("R9", "byte read returns zero", rv, 16'h0000);
      rd(A_DIR, rv, 2'b10);  chk("R9", "word read returns zero", rv, 16'h0000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule